// File: doc/BRIEF.md
# Parallel Golomb-Rice Block Decoder

This block turns one stored 128-bit block record back into the predictor seed and the fifteen signed residuals of a 4x4 pixel tile. Each residual was coded as a Golomb-Rice value with parameter k = 2: a 2-bit remainder, a unary quotient and a separate sign bit. The unary part is a run of ones closed by a zero, one run per residual. The decoder locates all fifteen closing zeros at the same time. It takes each quotient as the gap between neighbouring zeros, joins it to its remainder and applies the sign. No serial bit scan is used.

A separate raw flag travels beside the record. When the flag is set, the record holds the sixteen original pixels. The decoder then passes the record through untouched and marks the result as bypassed. The result is registered, so it appears one clock after the input strobe. A record whose unary length field is out of range, or which holds fewer than fifteen closing zeros inside its stated length, is reported as malformed.

Top module: `gr_block_decoder`

## Requirements
- R1: While reset is asserted, and until the first accepted record, o_valid, o_bypass and o_err are 0, and o_seed, o_diff and o_raw are all zero.
- R2: o_valid is 1 exactly one clock after a cycle with i_valid = 1. In a cycle without i_valid, o_seed, o_diff, o_raw, o_bypass and o_err keep the values they held before.
- R3: When i_raw_flag = 1, the result has o_bypass = 1, o_raw equal to i_payload, and o_err = 0, with o_seed and o_diff zero. This holds whatever the payload contains, including lengths that would otherwise be malformed.
- R4: The record fields are read from the MSB end: seed at bits [127:120] and unary length at [119:113]. The sign bits are at [112:98], with lane 0 at bit 112. The remainders are at [97:68], with lane 0 at [97:96]. The unary field occupies [67:0], and its first bit is bit 67.
- R5: Quotient i (lanes 0 to 14) equals the number of ones between the (i-1)-th and i-th zero of the unary field, counted from its first bit. The string 1011101111100110 decodes to 1, 3, 5, 0, 2.
- R6: The magnitude of lane i is quotient*4 + remainder. Lane i appears on o_diff[10*i+9 : 10*i].
- R7: A sign bit of 1 makes the lane value the 10-bit two's-complement negation of the magnitude. A sign bit of 0 leaves the magnitude as it is.
- R8: For a non-raw record, the result is malformed when the length field is greater than 68, or when fewer than 15 zeros lie in the first L unary bits (L being the length field). A malformed result has o_err = 1 and o_bypass = 0, with o_seed and o_diff zero.
- R9: Unary bits at positions at or beyond the length field have no effect on a well-formed result.
- R10: When the result is not a bypass, o_raw is zero.
- R11: Records on back-to-back cycles are decoded independently, one result per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| i_valid | input | 1 | A record is presented this cycle |
| i_raw_flag | input | 1 | 1 when the record holds uncompressed pixels |
| i_payload | input | 128 | Left-justified record |
| o_valid | output | 1 | Result strobe, one cycle after i_valid |
| o_bypass | output | 1 | Result is a raw pass-through |
| o_err | output | 1 | Record was malformed |
| o_seed | output | 8 | Recovered seed |
| o_diff | output | 150 | Fifteen signed 10-bit residuals, lane 0 in the low bits |
| o_raw | output | 128 | Raw pixels on bypass, zero otherwise |

## Verification
The raw-flag path and the malformed-record check can both apply to the same record. A raw record can carry bits in its length position that read as a length above 68, or a unary area with too few zeros. The bench drives such raw records, both directed and mixed into a random stream, and expects the bypass to win: o_bypass = 1, o_err = 0 and the payload unchanged. A behavioural model in the bench rebuilds every expected output by scanning the bits with integers. It compares against the design on every clock, including idle cycles, where the previous result must be held.

// File: rtl/gr_dec_pkg.sv
package gr_dec_pkg;
  localparam int PAY_W   = 128;
  localparam int SEED_W  = 8;
  localparam int LEN_W   = 7;
  localparam int LANES   = 15;
  localparam int REM_W   = 2;
  localparam int Q_W     = 8;
  localparam int DIFF_W  = Q_W + REM_W;
  localparam int UNARY_W = PAY_W - SEED_W - LEN_W - LANES - LANES * REM_W;
  localparam int POS_W   = $clog2(UNARY_W);
  localparam int CNT_W   = $clog2(UNARY_W + 1);
  localparam int SEED_HI = PAY_W - 1;
  localparam int LEN_HI  = SEED_HI - SEED_W;
  localparam int SIGN_HI = LEN_HI - LEN_W;
  localparam int REM_HI  = SIGN_HI - LANES;
  localparam int UN_HI   = REM_HI - LANES * REM_W;
endpackage

// File: rtl/gr_zero_locator.sv
module gr_zero_locator
  import gr_dec_pkg::*;
(
  input  logic [UNARY_W-1:0]     i_bits,
  input  logic [LEN_W-1:0]       i_len,
  output logic [LANES*Q_W-1:0]   o_quo,
  output logic                   o_short
);
  logic [UNARY_W-1:0] zero_at;
  logic [CNT_W-1:0]   zc   [UNARY_W];
  logic [POS_W-1:0]   pos  [LANES];
  logic               last_seen;

  // zero flags in scan order (index 0 = first unary bit) and running zero counts
  always_comb begin : prefix_count
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int j = 0; j < UNARY_W; j++) begin
      zero_at[j] = ~i_bits[UNARY_W-1-j];
      acc        = acc + CNT_W'(zero_at[j]);
      zc[j]      = acc;
    end
  end

  // every lane picks the one position whose running count equals its rank
  always_comb begin : pick_positions
    for (int i = 0; i < LANES; i++) begin
      pos[i] = '0;
      for (int j = 0; j < UNARY_W; j++) begin
        if (zero_at[j] && (zc[j] == CNT_W'(i + 1))) pos[i] = pos[i] | POS_W'(j);
      end
    end
  end

  always_comb begin : last_zero_check
    last_seen = 1'b0;
    for (int j = 0; j < UNARY_W; j++) begin
      if (zero_at[j] && (zc[j] == CNT_W'(LANES)) && (j < int'(i_len))) last_seen = 1'b1;
    end
  end

  assign o_short = ~last_seen;

  for (genvar i = 0; i < LANES; i++) begin : g_gap
    if (i == 0) begin : g_first
      assign o_quo[0 +: Q_W] = Q_W'(pos[0]);
    end else begin : g_rest
      assign o_quo[i*Q_W +: Q_W] = Q_W'(pos[i]) - Q_W'(pos[i-1]) - Q_W'(1);
    end
  end
endmodule

// File: rtl/gr_lane_rebuild.sv
module gr_lane_rebuild
  import gr_dec_pkg::*;
(
  input  logic [Q_W-1:0]    i_quo,
  input  logic [REM_W-1:0]  i_rem,
  input  logic              i_neg,
  output logic [DIFF_W-1:0] o_diff
);
  logic [DIFF_W-1:0] mag;

  assign mag    = {i_quo, i_rem};
  assign o_diff = i_neg ? (DIFF_W'(0) - mag) : mag;
endmodule

// File: rtl/gr_block_decoder.sv
module gr_block_decoder
  import gr_dec_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    i_valid,
  input  logic                    i_raw_flag,
  input  logic [PAY_W-1:0]        i_payload,
  output logic                    o_valid,
  output logic                    o_bypass,
  output logic                    o_err,
  output logic [SEED_W-1:0]       o_seed,
  output logic [LANES*DIFF_W-1:0] o_diff,
  output logic [PAY_W-1:0]        o_raw
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_m1, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m1 <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      rst_m1 <= 1'b1;
      srst_n <= rst_m1;
    end
  end

  // field split
  logic [SEED_W-1:0]      f_seed;
  logic [LEN_W-1:0]       f_len;
  logic [LANES-1:0]       f_sign;
  logic [LANES*REM_W-1:0] f_rem;
  logic [UNARY_W-1:0]     f_unary;

  assign f_seed  = i_payload[SEED_HI -: SEED_W];
  assign f_len   = i_payload[LEN_HI  -: LEN_W];
  assign f_sign  = i_payload[SIGN_HI -: LANES];
  assign f_rem   = i_payload[REM_HI  -: LANES*REM_W];
  assign f_unary = i_payload[UN_HI:0];

  logic [LANES*Q_W-1:0]    quo;
  logic                    too_few;
  logic [LANES*DIFF_W-1:0] lane_diff;

  gr_zero_locator u_locate (
    .i_bits  (f_unary),
    .i_len   (f_len),
    .o_quo   (quo),
    .o_short (too_few)
  );

  // lane 0 sits at the MSB end of the sign and remainder fields
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    gr_lane_rebuild u_lane (
      .i_quo  (quo[i*Q_W +: Q_W]),
      .i_rem  (f_rem[(LANES-1-i)*REM_W +: REM_W]),
      .i_neg  (f_sign[LANES-1-i]),
      .o_diff (lane_diff[i*DIFF_W +: DIFF_W])
    );
  end

  // next state
  logic                    bad_rec, good_rec;
  logic                    nx_bypass, nx_err;
  logic [SEED_W-1:0]       nx_seed;
  logic [LANES*DIFF_W-1:0] nx_diff;
  logic [PAY_W-1:0]        nx_raw;

  always_comb begin
    bad_rec   = ~i_raw_flag & (too_few | (int'(f_len) > UNARY_W));
    good_rec  = ~i_raw_flag & ~bad_rec;
    nx_bypass = i_raw_flag;
    nx_err    = bad_rec;
    nx_raw    = i_raw_flag ? i_payload : '0;
    nx_seed   = good_rec ? f_seed : '0;
    nx_diff   = good_rec ? lane_diff : '0;
  end

  // registers, loaded only when a record is accepted
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      o_valid  <= 1'b0;
      o_bypass <= 1'b0;
      o_err    <= 1'b0;
      o_seed   <= '0;
      o_diff   <= '0;
      o_raw    <= '0;
    end else begin
      o_valid <= i_valid;
      if (i_valid) begin
        o_bypass <= nx_bypass;
        o_err    <= nx_err;
        o_seed   <= nx_seed;
        o_diff   <= nx_diff;
        o_raw    <= nx_raw;
      end
    end
  end

  // checks next to the output stage
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!srst_n)
    i_valid |=> o_valid);
  p_valid_drop_r2: assert property (@(posedge clk) disable iff (!srst_n)
    !i_valid |=> !o_valid);
  p_hold_r2: assert property (@(posedge clk) disable iff (!srst_n)
    !i_valid |=> ($stable(o_diff) && $stable(o_seed) && $stable(o_raw) && $stable(o_err)));
  p_bypass_copy_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (i_valid && i_raw_flag) |=> (o_bypass && !o_err && o_raw == $past(i_payload)));
  p_long_len_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (i_valid && !i_raw_flag && (int'(f_len) > UNARY_W)) |=> o_err);
  p_err_clean_r8: assert property (@(posedge clk) disable iff (!srst_n)
    o_err |-> (!o_bypass && o_diff == '0 && o_seed == '0));
  p_raw_quiet_r10: assert property (@(posedge clk) disable iff (!srst_n)
    !o_bypass |-> (o_raw == '0));
endmodule

// File: tb/test_gr_block_decoder.sv
module test_gr_block_decoder;
  import gr_dec_pkg::*;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic                    i_valid, i_raw_flag;
  logic [PAY_W-1:0]        i_payload;
  logic                    o_valid, o_bypass, o_err;
  logic [SEED_W-1:0]       o_seed;
  logic [LANES*DIFF_W-1:0] o_diff;
  logic [PAY_W-1:0]        o_raw;

  always #2 clk = ~clk;

  gr_block_decoder i_gr_block_decoder (
    .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_raw_flag(i_raw_flag),
    .i_payload(i_payload), .o_valid(o_valid), .o_bypass(o_bypass), .o_err(o_err),
    .o_seed(o_seed), .o_diff(o_diff), .o_raw(o_raw)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic                    e_valid = 1'b0, e_byp = 1'b0, e_err = 1'b0;
  logic [SEED_W-1:0]       e_seed = '0;
  logic [LANES*DIFF_W-1:0] e_diff = '0;
  logic [PAY_W-1:0]        e_raw  = '0;

  // behavioural reference: bit scan with integers
  task automatic model(input logic [PAY_W-1:0] d, input logic raw);
    int len, cnt, run, q[LANES], mag, r;
    if (raw) begin
      e_byp = 1'b1; e_err = 1'b0; e_raw = d; e_seed = '0; e_diff = '0;
      return;
    end
    e_byp = 1'b0; e_raw = '0;
    len = int'(d[119:113]);
    cnt = 0; run = 0;
    for (int j = 0; j < 68; j++) begin
      if (j < len && cnt < LANES) begin
        if (d[67-j] == 1'b0) begin q[cnt] = run; cnt++; run = 0; end
        else run++;
      end
    end
    e_err = (len > 68) || (cnt < LANES);
    if (e_err) begin e_seed = '0; e_diff = '0; return; end
    e_seed = d[127:120];
    for (int i = 0; i < LANES; i++) begin
      r   = int'(d[97-2*i -: 2]);
      mag = q[i] * 4 + r;
      if (d[112-i]) mag = (1024 - mag) % 1024;
      e_diff[i*10 +: 10] = 10'(mag);
    end
  endtask

  task automatic compare();
    string tag;
    checks++;
    if (e_byp) tag = "R3"; else if (e_err) tag = "R8"; else tag = "R6";
    if (!e_valid) tag = "R2";
    if ({o_valid, o_bypass, o_err, o_seed, o_diff, o_raw} !==
        {e_valid, e_byp, e_err, e_seed, e_diff, e_raw}) begin
      errors++;
      $display("FAIL %s v/b/e act %b%b%b exp %b%b%b seed act %h exp %h diff act %h exp %h raw act %h exp %h",
               tag, o_valid, o_bypass, o_err, e_valid, e_byp, e_err, o_seed, e_seed,
               o_diff, e_diff, o_raw, e_raw);
    end
  endtask

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act %0d exp %0d", tag, act, exp);
    end
  endtask

  // one cycle: judge the previous cycle's result, then drive new inputs
  task automatic step(input logic v, input logic raw, input logic [PAY_W-1:0] d);
    @(negedge clk);
    compare();
    i_valid = v; i_raw_flag = raw; i_payload = d;
    e_valid = v;
    if (v) model(d, raw);
  endtask

  function automatic logic [PAY_W-1:0] build(input logic [7:0] seed, input logic [14:0] sg,
                                             input logic [29:0] rm, input int q[LANES],
                                             input logic [67:0] fill);
    logic [67:0] u;
    int p;
    u = fill; p = 0;
    for (int i = 0; i < LANES; i++) begin
      for (int k = 0; k < q[i]; k++) begin u[67-p] = 1'b1; p++; end
      u[67-p] = 1'b0; p++;
    end
    return {seed, 7'(p), sg, rm, u};
  endfunction

  int qz[LANES] = '{default: 0};
  int qx[LANES] = '{1, 3, 5, 0, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
  int qm[LANES] = '{53, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};

  initial begin
    logic [PAY_W-1:0] d;
    logic [LANES*DIFF_W-1:0] keep;
    rst_n = 1'b0; i_valid = 1'b0; i_raw_flag = 1'b0; i_payload = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid", o_valid, 0);
    chk("R1 flags", {o_bypass, o_err}, 0);
    chk("R1 data", (o_diff == '0 && o_seed == '0 && o_raw == '0), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R5: worked example, all signs positive, remainders zero
    d = build(8'hA5, 15'h0, 30'h0, qx, '0);
    step(1, 0, d);
    step(0, 0, '0);
    chk("R5 q0", o_diff[0 +: 10], 4);
    chk("R5 q1", o_diff[10 +: 10], 12);
    chk("R5 q2", o_diff[20 +: 10], 20);
    chk("R5 q3", o_diff[30 +: 10], 0);
    chk("R5 q4", o_diff[40 +: 10], 8);
    chk("R4 seed", o_seed, 8'hA5);

    // R6/R7: lane 0 remainder 3 negated, lane 1 remainder 1 positive
    d = build(8'h3C, 15'b100000000000000, {2'd3, 2'd1, 26'h0}, qx, '0);
    step(1, 0, d);
    step(0, 0, '0);
    chk("R7 neg lane0", o_diff[0 +: 10], 1024 - 7);
    chk("R6 lane1", o_diff[10 +: 10], 13);

    // R6: maximum length, lane 0 quotient 53, all negative
    d = build(8'hFF, 15'h7FFF, 30'h3FFF_FFFF, qm, '0);
    step(1, 0, d);
    step(0, 0, '0);
    chk("R6 max lane0", o_diff[0 +: 10], 1024 - 215);
    chk("R7 zero lane", o_diff[10 +: 10], 1024 - 3);

    // R9: filler beyond the length has no effect
    d = build(8'h11, 15'h1234, 30'h1555_5555, qx, '0);
    step(1, 0, d);
    step(0, 0, '0);
    keep = o_diff;
    d = build(8'h11, 15'h1234, 30'h1555_5555, qx, {68{1'b1}});
    step(1, 0, d);
    step(0, 0, '0);
    chk("R9 filler", (o_diff == keep), 1);

    // R8: too few zeros, short length, long length
    d = build(8'h22, 15'h0, 30'h0, qz, '0);
    d[67:0] = {68{1'b1}}; d[119:113] = 7'd30;
    step(1, 0, d);
    step(0, 0, '0);
    chk("R8 few zeros", o_err, 1);
    d = build(8'h22, 15'h0, 30'h0, qx, '0); d[119:113] = 7'd14;
    step(1, 0, d);
    step(0, 0, '0);
    chk("R8 short len", o_err, 1);
    d = build(8'h22, 15'h0, 30'h0, qz, '0); d[119:113] = 7'd100;
    step(1, 0, d);
    step(0, 0, '0);
    chk("R8 long len", o_err, 1);

    // R3: raw record that would also read as malformed; bypass wins
    d = {8'h5A, 7'd127, {113{1'b1}}};
    step(1, 1, d);
    step(0, 0, '0);
    chk("R3 bypass", {o_bypass, o_err}, 2'b10);
    chk("R3 raw", (o_raw == d), 1);
    // R10: next decoded record clears the raw copy
    step(1, 0, build(8'h01, 15'h0, 30'h0, qz, '0));
    step(0, 0, '0);
    chk("R10 raw zero", (o_raw == '0), 1);

    // R11/R2: random stream, compared every clock
    for (int n = 0; n < 400; n++) begin
      int q[LANES];
      int budget;
      budget = 53;
      for (int i = 0; i < LANES; i++) begin
        q[i] = ($urandom_range(0, 9) == 0) ? $urandom_range(0, budget)
                                           : $urandom_range(0, (budget < 5) ? budget : 5);
        budget -= q[i];
      end
      d = build(8'($urandom), 15'($urandom), 30'($urandom), q,
                {4'($urandom), 32'($urandom), 32'($urandom)});
      if ($urandom_range(0, 7) == 0) d[119:113] = 7'($urandom);
      step($urandom_range(0, 3) != 0, $urandom_range(0, 7) == 0, d);
    end
    step(0, 0, '0);
    step(0, 0, '0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog done act 0 exp 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule